// File: doc/BRIEF.md
# Cycle-Driven Interrupt Countdown Timer

This block is a programmable interval timer that runs on CPU bus cycles. Software loads a 16-bit count through two byte-wide register writes and chooses the counting direction from a shared mode register. Once armed, the count moves by one on every qualified bus cycle. When the count lands on zero, an active-low interrupt line goes low and the timer disarms itself. A write to the low-byte register acknowledges the interrupt.

The arm flag is not visible to software and cannot be written directly. It takes the value of the arm bit from the mode register only when software writes the high byte of the count. This lets software set up the mode once and then start a countdown by writing the high byte last. Registers are decoded from a masked address, so a register also answers at every alias the mask leaves open.

Top module: `cycirq_top`

## Requirements
- R1: A write whose address ANDed with 0x8C17 equals 0x8800 loads count bits 7:0 from the data bus and releases a pending interrupt, so `irq_n` is 1 in the cycle after that write.
- R2: A write whose masked address equals 0x8801 loads count bits 15:8 and copies `arm_sel` into the hidden arm flag. With `arm_sel` = 0 the count then stays frozen.
- R3: While armed and with a nonzero count, each cycle with `cyc_strobe` = 1 and no register write changes the count by one. It adds one when `count_down` = 0 and subtracts one when `count_down` = 1.
- R4: A step that leaves the count at zero drives `irq_n` low from the next cycle and clears the arm flag, so no later step occurs until the timer is armed again.
- R5: An armed timer whose count is zero does not step and raises no interrupt. It stays armed, so a later low-byte write of a nonzero value resumes counting.
- R6: Once low, `irq_n` stays low until an R1 write. A high-byte write may re-arm a new count while the interrupt is still pending.
- R7: A register write in the same cycle as a strobe takes priority, and that strobe is lost.
- R8: Adding one to 0xFFFF wraps to 0x0000, and this counts as reaching zero under R4.
- R9: Reset leaves `irq_n` at 1, the arm flag clear and the count at zero.
- R10: Writes to any other masked address (for example 0x8802 or 0x8C00) change neither the count, the arm flag nor the interrupt.
- R11: Cycles with `cyc_strobe` = 0 never step the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-cycle pulse for each counted bus cycle |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| arm_sel | input | 1 | Arm bit from the shared mode register |
| count_down | input | 1 | Direction bit from the shared mode register (1 = subtract) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The count itself is never visible at the ports. Every count value therefore has to be inferred from the exact cycle in which `irq_n` falls. The hardest case is a pending interrupt that is re-armed with a 256-step count and then acknowledged in the middle of the run. The stimulus first lets one countdown expire. It then writes only the high byte, so the count is 0x0100 and the interrupt stays pending. Part way through the run it writes the low byte, which both acknowledges the interrupt and alters the remaining count. A cycle-accurate reference model in the bench predicts the one cycle in which `irq_n` must fall again. Collisions between writes and strobes, and the wrap from 0xFFFF, are placed the same way, at chosen offsets before an expected fall.

// File: rtl/cycirq_pkg.sv
package cycirq_pkg;

   typedef enum logic {
      STEP_UP   = 1'b0,
      STEP_DOWN = 1'b1
   } step_dir_e;

   typedef struct packed {
      logic      go;
      step_dir_e dir;
   } step_req_t;

endpackage

// File: rtl/cycirq_decode.sv
module cycirq_decode #(
   parameter int unsigned          ADDR_W    = 16,
   parameter int unsigned          NUM_LANES = 2,
   parameter logic [ADDR_W-1:0]    ADDR_MASK = 16'h8C17,
   parameter logic [ADDR_W-1:0]    BASE_ADDR = 16'h8800
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic [NUM_LANES-1:0] lane_we,
   output logic                 any_we
);

   logic [ADDR_W-1:0] masked_addr;

   assign masked_addr = wr_addr & ADDR_MASK;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(g);
      assign lane_we[g] = wr_en && (masked_addr == LANE_ADDR);
   end

   assign any_we = |lane_we;

endmodule

// File: rtl/cycirq_counter.sv
module cycirq_counter
   import cycirq_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NUM_LANES = CNT_W / DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] lane_we,
   input  logic                 any_we,
   input  logic [DATA_W-1:0]    wr_data,
   input  step_req_t            step_req,
   output logic [CNT_W-1:0]     cnt_q,
   output logic                 zero_hit
);

   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] stepped;
   logic             step_go;

   assign step_go = step_req.go && !any_we && (cnt_q != '0);
   assign stepped = (step_req.dir == STEP_DOWN) ? (cnt_q - CNT_W'(1))
                                                : (cnt_q + CNT_W'(1));
   assign zero_hit = step_go && (stepped == '0);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      always_comb begin
         if (any_we) begin
            cnt_next[g*DATA_W +: DATA_W] = lane_we[g] ? wr_data
                                                      : cnt_q[g*DATA_W +: DATA_W];
         end else if (step_go) begin
            cnt_next[g*DATA_W +: DATA_W] = stepped[g*DATA_W +: DATA_W];
         end else begin
            cnt_next[g*DATA_W +: DATA_W] = cnt_q[g*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next;
   end

endmodule

// File: rtl/cycirq_flags.sv
module cycirq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_we,
   input  logic arm_we,
   input  logic arm_sel,
   input  logic zero_hit,
   output logic en_q,
   output logic pend_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (arm_we) begin
         en_q <= arm_sel;
      end else if (zero_hit) begin
         en_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (ack_we) begin
         pend_q <= 1'b0;
      end else if (zero_hit) begin
         pend_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cycirq_top.sv
module cycirq_top
   import cycirq_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       CNT_W     = 16,
   parameter logic [ADDR_W-1:0] ADDR_MASK = 16'h8C17,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_strobe,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              arm_sel,
   input  logic              count_down,
   output logic              irq_n
);

   localparam int unsigned NUM_LANES = CNT_W / DATA_W;
   localparam int unsigned TOP_LANE  = NUM_LANES - 1;

   if ((CNT_W % DATA_W) != 0) begin : g_bad_split
      $error("counter width must be a multiple of the data width");
   end
   if (NUM_LANES < 2) begin : g_bad_lanes
      $error("counter needs at least two byte lanes");
   end
   if ((BASE_ADDR & ~ADDR_MASK) != '0) begin : g_bad_base
      $error("base address has bits outside the decode mask");
   end

   logic [NUM_LANES-1:0] lane_we;
   logic                 any_we;
   logic [CNT_W-1:0]     cnt_q;
   logic                 zero_hit;
   logic                 en_q;
   logic                 pend_q;
   step_req_t            step_req;

   cycirq_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_LANES (NUM_LANES),
      .ADDR_MASK (ADDR_MASK),
      .BASE_ADDR (BASE_ADDR)
   ) decode_i (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .lane_we (lane_we),
      .any_we  (any_we)
   );

   assign step_req.go  = en_q && cyc_strobe;
   assign step_req.dir = count_down ? STEP_DOWN : STEP_UP;

   cycirq_counter #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) counter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_we  (lane_we),
      .any_we   (any_we),
      .wr_data  (wr_data),
      .step_req (step_req),
      .cnt_q    (cnt_q),
      .zero_hit (zero_hit)
   );

   cycirq_flags flags_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_we   (lane_we[0]),
      .arm_we   (lane_we[TOP_LANE]),
      .arm_sel  (arm_sel),
      .zero_hit (zero_hit),
      .en_q     (en_q),
      .pend_q   (pend_q)
   );

   assign irq_n = ~pend_q;

endmodule

// File: rtl/cycirq_chk.sv
module cycirq_chk #(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       CNT_W     = 16,
   parameter logic [ADDR_W-1:0] ADDR_MASK = 16'h8C17,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8800
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_strobe,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              arm_sel,
   input logic              count_down,
   input logic              irq_n,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              en_q
);

   localparam int unsigned NUM_LANES = CNT_W / DATA_W;
   localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(NUM_LANES - 1);

   logic [ADDR_W-1:0] m_addr;
   logic lo_hit, hi_hit, hit;
   logic step_live;

   assign m_addr    = wr_addr & ADDR_MASK;
   assign lo_hit    = wr_en && (m_addr == BASE_ADDR);
   assign hi_hit    = wr_en && (m_addr == TOP_ADDR);
   assign hit       = wr_en && (m_addr >= BASE_ADDR) && (m_addr <= TOP_ADDR);
   assign step_live = en_q && cyc_strobe && !hit && (cnt_q != '0);

   p_ack_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lo_hit |=> irq_n);

   p_low_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lo_hit |=> (cnt_q[DATA_W-1:0] == $past(wr_data)));

   p_arm_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_hit |=> (en_q == $past(arm_sel)));

   p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_live && !count_down) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_live && count_down) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   p_fire_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_live && count_down && cnt_q == CNT_W'(1)) |=> (!irq_n && !en_q));

   p_wrap_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_live && !count_down && (&cnt_q)) |=> (!irq_n && !en_q && cnt_q == '0));

   p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !hit) |=> (cnt_q == '0));

   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !lo_hit) |=> !irq_n);

   p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_strobe && !hit) |=> $stable(cnt_q));

   p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit && !cyc_strobe) |=> ($stable(cnt_q) && $stable(en_q) && $stable(irq_n)));

endmodule

bind cycirq_top cycirq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .ADDR_MASK (ADDR_MASK),
   .BASE_ADDR (BASE_ADDR)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_strobe (cyc_strobe),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .arm_sel    (arm_sel),
   .count_down (count_down),
   .irq_n      (irq_n),
   .cnt_q      (cnt_q),
   .en_q       (en_q)
);

// File: tb/cycirq_top_tb_top.sv
module cycirq_top_tb_top;

   typedef struct {
      logic  exp_irq_n;
      string tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_strobe = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        arm_sel = 1'b0;
   logic        count_down = 1'b0;
   logic        irq_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string cur_tag = "R9";

   exp_item_t sb_q[$];

   logic [15:0] m_cnt = '0;
   logic        m_en  = 1'b0;
   logic        m_pend = 1'b0;

   always #2 clk = ~clk;

   cycirq_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_strobe (cyc_strobe),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .arm_sel    (arm_sel),
      .count_down (count_down),
      .irq_n      (irq_n)
   );

   // monitor: compare one expected item per clock, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_item_t it;
         it = sb_q.pop_front();
         checks++;
         if (irq_n !== it.exp_irq_n) begin
            fails++;
            $display("FAIL %s: irq_n actual %0b expected %0b at %0t",
                     it.tag, irq_n, it.exp_irq_n, $time);
         end
      end
   end

   // driver: one bus cycle, reference model update, expected value pushed
   task automatic cyc(input bit strobe, input bit we, input logic [15:0] addr,
                      input logic [7:0] data);
      logic        lo, hi;
      logic [15:0] nxt;
      exp_item_t   it;
      @(negedge clk);
      cyc_strobe = strobe;
      wr_en      = we;
      wr_addr    = addr;
      wr_data    = data;
      lo = we && ((addr & 16'h8C17) == 16'h8800);
      hi = we && ((addr & 16'h8C17) == 16'h8801);
      if (!rst_n) begin
         m_cnt = '0; m_en = 1'b0; m_pend = 1'b0;
      end else if (lo) begin
         m_cnt[7:0] = data; m_pend = 1'b0;
      end else if (hi) begin
         m_cnt[15:8] = data; m_en = arm_sel;
      end else if (m_en && strobe && m_cnt != 16'h0) begin
         nxt = count_down ? m_cnt - 16'h1 : m_cnt + 16'h1;
         m_cnt = nxt;
         if (nxt == 16'h0) begin
            m_en = 1'b0; m_pend = 1'b1;
         end
      end
      it.exp_irq_n = ~m_pend;
      it.tag = cur_tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(input int n, input bit strobe);
      for (int i = 0; i < n; i++) cyc(strobe, 1'b0, 16'h0000, 8'h00);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      cur_tag = "R9";
      idle(3, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(4, 1'b1);

      // R2, R3, R4: down count of 3
      cur_tag = "R4";
      arm_sel = 1'b1; count_down = 1'b1;
      wr(16'h8800, 8'h03);
      wr(16'h8801, 8'h00);
      idle(6, 1'b1);

      // R1 + R10 alias: ack through an aliased address
      cur_tag = "R1";
      wr(16'hFBE8, 8'h00);
      idle(2, 1'b1);

      // R5: armed with zero count, nothing happens; then a low write resumes
      cur_tag = "R5";
      wr(16'h8801, 8'h00);
      idle(5, 1'b1);
      wr(16'h8800, 8'h02);
      idle(4, 1'b1);
      wr(16'h8800, 8'h00);

      // R3 up, R8 wrap from 0xFFFF
      cur_tag = "R8";
      count_down = 1'b0;
      wr(16'h8800, 8'hFE);
      wr(16'h8801, 8'hFF);
      idle(4, 1'b1);
      wr(16'h8800, 8'h00);

      // R7: writes collide with strobes and win
      cur_tag = "R7";
      count_down = 1'b1;
      wr(16'h8800, 8'h02);
      wr(16'h8801, 8'h00);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 16'h8800, 8'h02);
      idle(3, 1'b1);

      // R6: re-arm while pending, ack mid-count
      cur_tag = "R6";
      wr(16'h8801, 8'h01);
      idle(40, 1'b1);
      wr(16'h8800, 8'h10);
      idle(300, 1'b1);

      // R10: foreign addresses neither ack nor load
      cur_tag = "R10";
      wr(16'h8802, 8'h55);
      wr(16'h8C00, 8'h55);
      idle(3, 1'b0);
      wr(16'h8800, 8'h00);

      // R11: no strobe, no step
      cur_tag = "R11";
      wr(16'h8800, 8'h01);
      wr(16'h8801, 8'h00);
      idle(6, 1'b0);
      idle(3, 1'b1);
      wr(16'h8800, 8'h00);

      // R2: disarming high write freezes the count
      cur_tag = "R2";
      arm_sel = 1'b0;
      wr(16'h8800, 8'h01);
      wr(16'h8801, 8'h00);
      idle(6, 1'b1);
      arm_sel = 1'b1;
      wr(16'h8801, 8'h00);
      idle(3, 1'b1);

      idle(2, 1'b0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule